// File: doc/BRIEF.md
# Event-Driven PWM Polarity Controller

This block is the output stage of one timer channel. It holds a single output level and updates it whenever the counter reports one of three events: counting has started, counting has stopped, or the count has reached the compare value. Each event arrives as a one-cycle strobe. Each event has its own 2-bit action code, which selects what happens to the level. The code can force the level low, force it high, or keep it. A compare match can also invert the level.

The level is held in an internal register. An enable input gates that level onto the pin. While the enable is low the pin stays at 0, but the internal level keeps following events. A channel that is enabled later therefore shows the level that the event history has produced. The pin is registered, so it follows an event one clock after the strobe.

Top module: `pwm_pol_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, the internal level is 0 and the pin is 0.
- R2: The start strobe applies start_act. Code 0 sets the level to 0 and code 1 sets it to 1. Code 2 keeps the level, and code 3 also keeps it.
- R3: The stop strobe applies stop_act with the same encoding: 0 low, 1 high, 2 keep, 3 keep.
- R4: The match strobe applies match_act. Code 0 sets the level low, 1 sets it high, 2 keeps it and 3 inverts it.
- R5: When strobes coincide, only one action applies. Stop wins over match and start, and match wins over start.
- R6: In a cycle with no strobe, the level holds its value.
- R7: While out_en is low the pin is 0, and the level still follows the strobes. Once out_en is high, the pin shows the level at the next clock edge.
- R8: The pin is registered. After a strobe it changes only at the clock edge that samples that strobe, never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Gates the level onto the pin |
| start_act | input | 2 | Action code applied on the start strobe |
| stop_act | input | 2 | Action code applied on the stop strobe |
| match_act | input | 2 | Action code applied on the match strobe |
| evt_start | input | 1 | One-cycle strobe: counting started |
| evt_stop | input | 1 | One-cycle strobe: counting stopped |
| evt_match | input | 1 | One-cycle strobe: count equals compare value |
| pwm_pin | output | 1 | Registered, gated PWM output |

## Verification
A wrong internal level is hidden while out_en is low. It appears on the pin one clock after out_en is high, and from then on every keep or invert action carries the error forward. The bench therefore checks the pin in every cycle against a reference model of the level, including the cycles that follow enable-low stretches and the cycles with no strobe. A wrong priority or a wrong decode of a code shows on the pin at the edge that samples the offending strobe. The bench uses the codes 2 and 3, whose result depends on the previous level, so that such an error cannot hide behind a forced value.

// File: rtl/pwm_pol_pkg.sv
package pwm_pol_pkg;
  parameter int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_LOW  = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_KEEP = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  // Start/stop have no invert action: the spare code degrades to keep.
  function automatic act_e edge_code(input logic [ACT_W-1:0] code);
    act_e r;
    r = act_e'(code);
    if (r == ACT_FLIP) r = ACT_KEEP;
    return r;
  endfunction
endpackage

// File: rtl/pwm_evt_arb.sv
module pwm_evt_arb
  import pwm_pol_pkg::*;
(
  input  logic             evt_start,
  input  logic             evt_stop,
  input  logic             evt_match,
  input  logic [ACT_W-1:0] start_act,
  input  logic [ACT_W-1:0] stop_act,
  input  logic [ACT_W-1:0] match_act,
  output logic             sel_vld,
  output act_e             sel_act
);
  // Fixed priority: stop, then match, then start.
  always_comb begin
    sel_vld = 1'b1;
    sel_act = ACT_KEEP;
    if (evt_stop)       sel_act = edge_code(stop_act);
    else if (evt_match) sel_act = act_e'(match_act);
    else if (evt_start) sel_act = edge_code(start_act);
    else                sel_vld = 1'b0;
  end

  always_comb begin
    if (evt_stop) assert (sel_act != ACT_FLIP); // R3
  end
endmodule

// File: rtl/pwm_level_reg.sv
module pwm_level_reg
  import pwm_pol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_vld,
  input  act_e             sel_act,
  input  logic             evt_start,
  input  logic             evt_stop,
  input  logic             evt_match,
  input  logic [ACT_W-1:0] start_act,
  input  logic [ACT_W-1:0] stop_act,
  input  logic [ACT_W-1:0] match_act,
  output logic             lvl_d,
  output logic             lvl_q
);
  logic lvl_ce;

  assign lvl_ce = sel_vld;

  always_comb begin
    lvl_d = lvl_q;
    if (lvl_ce) begin
      unique case (sel_act)
        ACT_LOW:  lvl_d = 1'b0;
        ACT_HIGH: lvl_d = 1'b1;
        ACT_KEEP: lvl_d = lvl_q;
        ACT_FLIP: lvl_d = ~lvl_q;
        default:  lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= 1'b0;
    else if (lvl_ce) lvl_q <= lvl_d;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_start && !evt_stop && !evt_match) |=> $stable(lvl_q)); // R6
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stop && stop_act == 2'd0) |=> !lvl_q); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stop && evt_match && stop_act == 2'd1) |=> lvl_q); // R5
  AST_MATCH_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_match && !evt_stop && match_act == 2'd3) |=> (lvl_q != $past(lvl_q))); // R4
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start && !evt_stop && !evt_match && start_act == 2'd1) |=> lvl_q); // R2
endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic lvl_d,
  output logic pin_q
);
  logic pin_d;

  assign pin_d = out_en & lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  AST_EN_LOW_PIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !pin_q); // R7
endmodule

// File: rtl/pwm_pol_ctrl.sv
module pwm_pol_ctrl
  import pwm_pol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_en,
  input  logic [ACT_W-1:0] start_act,
  input  logic [ACT_W-1:0] stop_act,
  input  logic [ACT_W-1:0] match_act,
  input  logic             evt_start,
  input  logic             evt_stop,
  input  logic             evt_match,
  output logic             pwm_pin
);
  logic sel_vld;
  act_e sel_act;
  logic lvl_d;
  logic lvl_q;

  pwm_evt_arb u_arb (
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .evt_match (evt_match),
    .start_act (start_act),
    .stop_act  (stop_act),
    .match_act (match_act),
    .sel_vld   (sel_vld),
    .sel_act   (sel_act)
  );

  pwm_level_reg u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_vld   (sel_vld),
    .sel_act   (sel_act),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .evt_match (evt_match),
    .start_act (start_act),
    .stop_act  (stop_act),
    .match_act (match_act),
    .lvl_d     (lvl_d),
    .lvl_q     (lvl_q)
  );

  pwm_pin_stage u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .out_en(out_en),
    .lvl_d (lvl_d),
    .pin_q (pwm_pin)
  );

  AST_PIN_TRACKS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> (pwm_pin == lvl_q)); // R7
  always_comb begin
    if (!rst_n) assert (!pwm_pin && !lvl_q); // R1
  end
endmodule

// File: tb/pwm_pol_ctrl_tb.sv
module pwm_pol_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       out_en = 1'b0;
  logic [1:0] start_act = 2'd0, stop_act = 2'd0, match_act = 2'd0;
  logic       evt_start = 1'b0, evt_stop = 1'b0, evt_match = 1'b0;
  logic       pwm_pin;

  int n_chk = 0;
  int n_bad = 0;
  logic  mdl_lvl = 1'b0;
  logic  exp_q[$];
  string req_q[$];

  always #10 clk = ~clk; // 50 MHz

  pwm_pol_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .out_en(out_en),
    .start_act(start_act), .stop_act(stop_act), .match_act(match_act),
    .evt_start(evt_start), .evt_stop(evt_stop), .evt_match(evt_match),
    .pwm_pin(pwm_pin)
  );

  function automatic logic edge_apply(input logic [1:0] c, input logic cur);
    if (c == 2'd0) return 1'b0;
    if (c == 2'd1) return 1'b1;
    return cur;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm_pin=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: sets one cycle of stimulus and queues the expected pin value.
  task automatic drive(input logic en, input logic [1:0] sa, input logic [1:0] pa,
                       input logic [1:0] ma, input logic s, input logic p,
                       input logic m, input string req);
    @(negedge clk);
    out_en = en; start_act = sa; stop_act = pa; match_act = ma;
    evt_start = s; evt_stop = p; evt_match = m;
    if (p)      mdl_lvl = edge_apply(pa, mdl_lvl);
    else if (m) mdl_lvl = (ma == 2'd3) ? ~mdl_lvl : edge_apply(ma, mdl_lvl);
    else if (s) mdl_lvl = edge_apply(sa, mdl_lvl);
    exp_q.push_back(en & mdl_lvl);
    req_q.push_back(req);
  endtask

  task automatic idle(input logic en, input string req);
    drive(en, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, req);
  endtask

  // Monitor: compares after each rising edge, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) check(pwm_pin, exp_q.pop_front(), req_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pwm_pin, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    idle(1'b1, "R1 after reset");
    // R2 start codes
    drive(1, 2'd1, 0, 0, 1, 0, 0, "R2 start high");
    idle(1'b1, "R6 hold high");
    idle(1'b1, "R6 hold high again");
    drive(1, 2'd2, 0, 0, 1, 0, 0, "R2 start keep");
    drive(1, 2'd3, 0, 0, 1, 0, 0, "R2 start code3 keep");
    drive(1, 2'd0, 0, 0, 1, 0, 0, "R2 start low");
    drive(1, 2'd3, 0, 0, 1, 0, 0, "R2 start code3 keep low");
    // R3 stop codes
    drive(1, 0, 2'd1, 0, 0, 1, 0, "R3 stop high");
    drive(1, 0, 2'd2, 0, 0, 1, 0, "R3 stop keep");
    drive(1, 0, 2'd3, 0, 0, 1, 0, "R3 stop code3 keep");
    drive(1, 0, 2'd0, 0, 0, 1, 0, "R3 stop low");
    // R4 match codes
    drive(1, 0, 0, 2'd3, 0, 0, 1, "R4 match invert to 1");
    drive(1, 0, 0, 2'd3, 0, 0, 1, "R4 match invert to 0");
    drive(1, 0, 0, 2'd1, 0, 0, 1, "R4 match high");
    drive(1, 0, 0, 2'd2, 0, 0, 1, "R4 match keep");
    drive(1, 0, 0, 2'd0, 0, 0, 1, "R4 match low");
    // R5 priority
    drive(1, 2'd1, 2'd0, 2'd1, 1, 1, 1, "R5 stop over match and start");
    drive(1, 2'd0, 2'd0, 2'd3, 1, 0, 1, "R5 match over start");
    drive(1, 2'd1, 2'd2, 2'd3, 1, 1, 1, "R5 stop keep blocks invert");
    drive(1, 2'd0, 2'd2, 2'd3, 0, 1, 1, "R5 stop keep blocks invert again");
    // R7 enable gating
    drive(0, 2'd0, 0, 2'd3, 0, 0, 1, "R7 disabled invert");
    drive(0, 2'd1, 0, 0, 1, 0, 0, "R7 disabled start high");
    idle(1'b0, "R7 disabled idle");
    idle(1'b1, "R7 enable shows level");
    drive(0, 0, 0, 2'd3, 0, 0, 1, "R7 disabled invert to 0");
    idle(1'b1, "R7 enable shows 0");
    // R8 latency: pin must not move before the sampling edge
    @(negedge clk);
    out_en = 1'b1; start_act = 2'd1; evt_start = 1'b1;
    evt_stop = 1'b0; evt_match = 1'b0;
    #3;
    check(pwm_pin, 1'b0, "R8 no change before edge");
    @(posedge clk); #5;
    check(pwm_pin, 1'b1, "R8 change after edge");
    mdl_lvl = 1'b1;
    idle(1'b1, "R6 idle after R8");
    idle(1'b1, "drain");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule